// File: doc/BRIEF.md
# Panel Bring-up and Standby Sequencer

This block brings a display panel controller out of reset and moves it between its standby and active states. It does this through a serial register master that sits next to it. The sequencer owns the panel's reset line. It issues single register commands through a valid/ready handshake, then waits for a done strobe before it continues. It never drives the serial wires itself.

On the first enable request after reset, the sequencer releases the panel reset. It then waits a programmable number of milliseconds and runs a self-test: it writes a pattern to a scratch register and reads it back. It also reads three status registers and keeps the decoded fields on its outputs. After the self-test it leaves standby by setting the wake bit of the mode register with a read-modify-write. Later enable requests, and all disable requests, do only that read-modify-write, setting or clearing the wake bit. A request that arrives during a sequence is held and served afterwards.

Top module: `pnl_bringup_seq`

## Requirements
- R1: `panel_rst` is 1 from reset until the first enable request is taken, and then stays 0 until the next reset. No command is issued while `panel_rst` is 1.
- R2: After `panel_rst` falls, no command is issued for at least `ms_cycles * WAIT_MS` clock cycles.
- R3: The bring-up issues, in this order, write addr 0 data 0x55, read addr 0, read addr 1, read addr 2, read addr 3. `link_ok` is 1 only if the read of addr 0 returned 0x55.
- R4: `chip_id` is bits 7:4 and `version` is bits 3:0 of the value read from addr 1.
- R5: `res_code` is bits 2:0 of the value read from addr 2. `res_illegal` is 1 exactly when that code is 2 or 3.
- R6: `sw_ctrl` is bit 7 of the value read from addr 3 during bring-up (1 = software control, 0 = hardware control).
- R7: Every enable ends with read addr 3 followed by write addr 3 of the value read with bit 0 set and all other bits unchanged. Enables after the first one issue only these two commands.
- R8: A disable issues read addr 3, then write addr 3 of the value read with bit 0 cleared. A disable taken before any bring-up is dropped: no command, no busy, no done, and `panel_rst` stays 1.
- R9: A request that arrives during a sequence is served after that sequence. A newer request replaces an older pending one. Enable and disable in the same cycle count as an enable.
- R10: `cmd_valid` and its write, address and data fields hold steady until `cmd_ready`. No new command is issued before the previous one's `cmd_done`.
- R11: `busy` is 1 while a sequence runs, including whenever `cmd_valid` is 1. `seq_done` is a one-cycle pulse at the end of each served sequence, with `busy` already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_cycles | input | CNT_W | Clock cycles per millisecond (0 treated as 1) |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle end-of-sequence pulse |
| panel_rst | output | 1 | Panel reset, active high |
| cmd_valid | output | 1 | Command offered to the serial master |
| cmd_ready | input | 1 | Serial master accepts the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | 6 | Panel register address |
| cmd_wdata | output | 8 | Write data |
| cmd_rdata | input | 8 | Read data, valid with cmd_done |
| cmd_done | input | 1 | Serial transfer finished |
| link_ok | output | 1 | Scratch pattern read back intact |
| chip_id | output | 4 | Identity field of register 1 |
| version | output | 4 | Revision field of register 1 |
| res_code | output | 3 | Resolution code from register 2 |
| res_illegal | output | 1 | Resolution code is 2 or 3 |
| sw_ctrl | output | 1 | Mode register bit 7 seen at bring-up |

## Verification
The in-RTL properties assume the serial master behaves: it raises `cmd_ready` only while `cmd_valid` is high, and gives exactly one `cmd_done` per accepted command, never before acceptance. The bench's responder model follows this rule. It raises ready only for an offered command with nothing outstanding, drops ready on acceptance, and sends one done after a fixed latency. Each round varies the ready gap and done latency. Requests are applied as one-cycle pulses at the falling edge. Status registers are preloaded only while reset is asserted.

// File: rtl/pnl_seq_pkg.sv
package pnl_seq_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int RES_W  = 3;
  localparam int STEP_W = 3;

  // sequence step numbers, bring-up runs 0..6, standby change runs 5..6
  localparam logic [STEP_W-1:0] ST_LINK_WR = 3'd0;
  localparam logic [STEP_W-1:0] ST_LINK_RD = 3'd1;
  localparam logic [STEP_W-1:0] ST_ID_RD   = 3'd2;
  localparam logic [STEP_W-1:0] ST_RES_RD  = 3'd3;
  localparam logic [STEP_W-1:0] ST_CTL_RD  = 3'd4;
  localparam logic [STEP_W-1:0] ST_MODE_RD = 3'd5;
  localparam logic [STEP_W-1:0] ST_MODE_WR = 3'd6;

  localparam logic [ADDR_W-1:0] A_SCRATCH = 6'd0;
  localparam logic [ADDR_W-1:0] A_IDENT   = 6'd1;
  localparam logic [ADDR_W-1:0] A_RESOL   = 6'd2;
  localparam logic [ADDR_W-1:0] A_MODE    = 6'd3;

  localparam int MODE_ON_BIT  = 0;
  localparam int MODE_SRC_BIT = 7;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_ISSUE, S_WAIT} seq_state_e;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } pnl_cmd_t;

  function automatic pnl_cmd_t step_cmd(input logic [STEP_W-1:0] step,
                                        input logic [DATA_W-1:0] pattern,
                                        input logic [DATA_W-1:0] prev_rd,
                                        input logic              wake);
    pnl_cmd_t c;
    c.wr    = 1'b0;
    c.addr  = A_MODE;
    c.wdata = '0;
    case (step)
      ST_LINK_WR: begin c.wr = 1'b1; c.addr = A_SCRATCH; c.wdata = pattern; end
      ST_LINK_RD: c.addr = A_SCRATCH;
      ST_ID_RD:   c.addr = A_IDENT;
      ST_RES_RD:  c.addr = A_RESOL;
      ST_MODE_WR: begin
        c.wr = 1'b1;
        c.wdata = prev_rd;
        c.wdata[MODE_ON_BIT] = wake;
      end
      default: ;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pnl_req_latch.sv
module pnl_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic en_req,
  input  logic dis_req,
  input  logic take,
  output logic pend_valid,
  output logic pend_wake
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid <= 1'b0;
      pend_wake  <= 1'b0;
    end else if (en_req || dis_req) begin
      pend_valid <= 1'b1;
      pend_wake  <= en_req;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  // R9
  newest_disable_chk: assert property (@(posedge clk) disable iff (rst)
    (dis_req && !en_req) |=> (pend_valid && !pend_wake));

  // R9
  newest_enable_chk: assert property (@(posedge clk) disable iff (rst)
    en_req |=> (pend_valid && pend_wake));
endmodule

// File: rtl/pnl_ms_timer.sv
module pnl_ms_timer #(
  parameter int CNT_W   = 16,
  parameter int WAIT_MS = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] ms_cycles,
  output logic             expired
);
  localparam int MS_W = (WAIT_MS > 1) ? $clog2(WAIT_MS) : 1;

  logic [CNT_W-1:0] cyc_q;
  logic             run_q;
  logic             last_cyc;
  logic             last_ms;

  assign last_cyc = ({1'b0, cyc_q} + (CNT_W+1)'(1)) >= {1'b0, ms_cycles};

  generate
    if (WAIT_MS <= 1) begin : g_single
      assign last_ms = 1'b1;
    end else begin : g_multi
      logic [MS_W-1:0] ms_q;
      always_ff @(posedge clk) begin
        if (rst || start)
          ms_q <= '0;
        else if (run_q && last_cyc)
          ms_q <= last_ms ? '0 : ms_q + MS_W'(1);
      end
      assign last_ms = (ms_q == MS_W'(WAIT_MS - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      cyc_q   <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        run_q <= 1'b1;
        cyc_q <= '0;
      end else if (run_q) begin
        if (last_cyc) begin
          cyc_q <= '0;
          if (last_ms) begin
            run_q   <= 1'b0;
            expired <= 1'b1;
          end
        end else begin
          cyc_q <= cyc_q + CNT_W'(1);
        end
      end
    end
  end

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q);

  // R2
  expiry_after_run_chk: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(run_q));
endmodule

// File: rtl/pnl_status_regs.sv
module pnl_status_regs
  import pnl_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0]      LINK_PAT     = 8'h55,
  parameter logic [(1<<RES_W)-1:0]  BAD_RES_MASK = 8'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic [STEP_W-1:0] step,
  input  logic [DATA_W-1:0] rdata,
  output logic              link_ok,
  output logic [NIB_W-1:0]  chip_id,
  output logic [NIB_W-1:0]  version,
  output logic [RES_W-1:0]  res_code,
  output logic              res_illegal,
  output logic              sw_ctrl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      link_ok     <= 1'b0;
      chip_id     <= '0;
      version     <= '0;
      res_code    <= '0;
      res_illegal <= 1'b0;
      sw_ctrl     <= 1'b0;
    end else if (cap) begin
      case (step)
        ST_LINK_RD: link_ok <= (rdata == LINK_PAT);
        ST_ID_RD: begin
          chip_id <= rdata[DATA_W-1:NIB_W];
          version <= rdata[NIB_W-1:0];
        end
        ST_RES_RD: begin
          res_code    <= rdata[RES_W-1:0];
          res_illegal <= BAD_RES_MASK[rdata[RES_W-1:0]];
        end
        ST_CTL_RD: sw_ctrl <= rdata[MODE_SRC_BIT];
        default: ;
      endcase
    end
  end

  // R4
  ident_only_on_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cap) |-> ($stable(chip_id) && $stable(version)));
endmodule

// File: rtl/pnl_bringup_seq.sv
module pnl_bringup_seq
  import pnl_seq_pkg::*;
#(
  parameter int                     CNT_W        = 16,
  parameter int                     WAIT_MS      = 1,
  parameter logic [DATA_W-1:0]      LINK_PAT     = 8'h55,
  parameter logic [(1<<RES_W)-1:0]  BAD_RES_MASK = 8'h0C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  ms_cycles,
  input  logic              en_req,
  input  logic              dis_req,
  output logic              busy,
  output logic              seq_done,
  output logic              panel_rst,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic [DATA_W-1:0] cmd_rdata,
  input  logic              cmd_done,
  output logic              link_ok,
  output logic [NIB_W-1:0]  chip_id,
  output logic [NIB_W-1:0]  version,
  output logic [RES_W-1:0]  res_code,
  output logic              res_illegal,
  output logic              sw_ctrl
);
  seq_state_e        st_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] load_step;
  logic              wake_q;
  logic              up_q;
  logic              pend_valid;
  logic              pend_wake;
  logic              take;
  logic              tmr_start;
  logic              tmr_exp;
  logic              rsp;
  pnl_cmd_t          nxt_cmd;

  assign take      = (st_q == S_IDLE) && pend_valid;
  assign tmr_start = take && pend_wake && !up_q;
  assign rsp       = (st_q == S_WAIT) && cmd_done;

  pnl_req_latch u_req (
    .clk        (clk),
    .rst        (rst),
    .en_req     (en_req),
    .dis_req    (dis_req),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_wake  (pend_wake)
  );

  pnl_ms_timer #(.CNT_W(CNT_W), .WAIT_MS(WAIT_MS)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .start     (tmr_start),
    .ms_cycles (ms_cycles),
    .expired   (tmr_exp)
  );

  pnl_status_regs #(.LINK_PAT(LINK_PAT), .BAD_RES_MASK(BAD_RES_MASK)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .cap         (rsp),
    .step        (step_q),
    .rdata       (cmd_rdata),
    .link_ok     (link_ok),
    .chip_id     (chip_id),
    .version     (version),
    .res_code    (res_code),
    .res_illegal (res_illegal),
    .sw_ctrl     (sw_ctrl)
  );

  always_comb begin
    load_step = ST_MODE_RD;
    if (st_q == S_HOLD)      load_step = ST_LINK_WR;
    else if (st_q == S_WAIT) load_step = step_q + 3'd1;
  end

  assign nxt_cmd = step_cmd(load_step, LINK_PAT, cmd_rdata,
                            (st_q == S_IDLE) ? pend_wake : wake_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      step_q    <= '0;
      wake_q    <= 1'b0;
      up_q      <= 1'b0;
      panel_rst <= 1'b1;
      busy      <= 1'b0;
      seq_done  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_write <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
    end else begin
      seq_done <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (pend_valid) begin
            wake_q <= pend_wake;
            if (pend_wake && !up_q) begin
              panel_rst <= 1'b0;
              busy      <= 1'b1;
              st_q      <= S_HOLD;
            end else if (up_q) begin
              busy      <= 1'b1;
              step_q    <= load_step;
              cmd_valid <= 1'b1;
              cmd_write <= nxt_cmd.wr;
              cmd_addr  <= nxt_cmd.addr;
              cmd_wdata <= nxt_cmd.wdata;
              st_q      <= S_ISSUE;
            end
          end
        end
        S_HOLD: begin
          if (tmr_exp) begin
            step_q    <= load_step;
            cmd_valid <= 1'b1;
            cmd_write <= nxt_cmd.wr;
            cmd_addr  <= nxt_cmd.addr;
            cmd_wdata <= nxt_cmd.wdata;
            st_q      <= S_ISSUE;
          end
        end
        S_ISSUE: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            st_q      <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (cmd_done) begin
            if (step_q == ST_MODE_WR) begin
              busy     <= 1'b0;
              seq_done <= 1'b1;
              up_q     <= 1'b1;
              st_q     <= S_IDLE;
            end else begin
              step_q    <= load_step;
              cmd_valid <= 1'b1;
              cmd_write <= nxt_cmd.wr;
              cmd_addr  <= nxt_cmd.addr;
              cmd_wdata <= nxt_cmd.wdata;
              st_q      <= S_ISSUE;
            end
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R1
  reset_stays_released_chk: assert property (@(posedge clk) disable iff (rst)
    !panel_rst |=> !panel_rst);

  // R1
  no_access_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    panel_rst |-> !cmd_valid);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write)
                                   && $stable(cmd_addr) && $stable(cmd_wdata)));

  // R11
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> busy);

  // R11
  done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> (!busy && $past(busy)));

  // R8
  mode_bit_match_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_write && cmd_addr == A_MODE) |-> (cmd_wdata[MODE_ON_BIT] == wake_q));
endmodule

// File: tb/pnl_bringup_seq_test.sv
module pnl_bringup_seq_test;
  import pnl_seq_pkg::*;

  localparam int CLK_NS = 10;
  localparam int CW     = 12;
  localparam int WMS    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] ms_cycles = '0;
  logic en_req = 1'b0, dis_req = 1'b0;
  logic busy, seq_done, panel_rst, cmd_valid, cmd_write;
  logic cmd_ready, cmd_done;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_wdata, cmd_rdata;
  logic link_ok, res_illegal, sw_ctrl;
  logic [NIB_W-1:0] chip_id, version;
  logic [RES_W-1:0] res_code;

  always #(CLK_NS/2) clk = ~clk;

  pnl_bringup_seq #(.CNT_W(CW), .WAIT_MS(WMS)) uut (
    .clk(clk), .rst(rst), .ms_cycles(ms_cycles), .en_req(en_req), .dis_req(dis_req),
    .busy(busy), .seq_done(seq_done), .panel_rst(panel_rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .cmd_done(cmd_done),
    .link_ok(link_ok), .chip_id(chip_id), .version(version), .res_code(res_code),
    .res_illegal(res_illegal), .sw_ctrl(sw_ctrl)
  );

  int checks = 0, errors = 0;

  // responder model of the serial master
  int rdy_gap = 0, done_lat = 0;
  bit corrupt = 1'b0;
  logic [7:0] pre1 = '0, pre2 = '0, pre3 = '0;
  logic [7:0] mregs [0:3];
  int log_w [0:63];
  int log_a [0:63];
  int log_d [0:63];
  int lcnt, wcnt, lat_cnt;
  logic outst;
  logic pw;
  logic [1:0] pa;
  logic [7:0] pd;

  always @(posedge clk) begin
    cmd_done <= 1'b0;
    if (rst) begin
      cmd_ready <= 1'b0; outst <= 1'b0; wcnt <= 0; lcnt <= 0; lat_cnt <= 0;
      cmd_rdata <= '0; pw <= 1'b0; pa <= '0; pd <= '0;
      mregs[0] <= 8'h00; mregs[1] <= pre1; mregs[2] <= pre2; mregs[3] <= pre3;
    end else begin
      if (cmd_valid && !outst && !cmd_ready) begin
        if (wcnt >= rdy_gap) begin cmd_ready <= 1'b1; wcnt <= 0; end
        else wcnt <= wcnt + 1;
      end
      if (cmd_valid && cmd_ready) begin
        cmd_ready <= 1'b0; outst <= 1'b1; lat_cnt <= 0;
        pw <= cmd_write; pa <= cmd_addr[1:0]; pd <= cmd_wdata;
        log_w[lcnt] <= int'(cmd_write);
        log_a[lcnt] <= int'(cmd_addr);
        log_d[lcnt] <= cmd_write ? int'(cmd_wdata) : 0;
        lcnt <= lcnt + 1;
      end
      if (outst) begin
        if (lat_cnt >= done_lat) begin
          outst <= 1'b0; cmd_done <= 1'b1;
          if (pw) mregs[pa] <= pd;
          else cmd_rdata <= (pa == 2'd0 && corrupt) ? (mregs[pa] ^ 8'hFF) : mregs[pa];
        end else lat_cnt <= lat_cnt + 1;
      end
    end
  end

  // protocol monitors
  int done_cnt, gcnt, gap;
  bit busy_seen, gseen;
  int busy_err = 0, viol = 0, stab_err = 0, dn_err = 0;
  logic hold_q;
  logic hw; logic [ADDR_W-1:0] ha; logic [DATA_W-1:0] hd;

  always @(posedge clk) begin
    if (rst) begin
      done_cnt <= 0; busy_seen <= 1'b0; gcnt <= 0; gap <= 0; gseen <= 1'b0; hold_q <= 1'b0;
    end else begin
      if (seq_done) begin
        done_cnt <= done_cnt + 1;
        if (busy) dn_err <= dn_err + 1;
      end
      if (busy) busy_seen <= 1'b1;
      if (cmd_valid && !busy) busy_err <= busy_err + 1;
      if (cmd_valid && outst) viol <= viol + 1;
      if (hold_q && (!cmd_valid || cmd_write != hw || cmd_addr != ha || cmd_wdata != hd))
        stab_err <= stab_err + 1;
      hold_q <= cmd_valid && !cmd_ready;
      hw <= cmd_write; ha <= cmd_addr; hd <= cmd_wdata;
      if (!panel_rst && !gseen) begin
        if (cmd_valid) begin gseen <= 1'b1; gap <= gcnt; end
        else gcnt <= gcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cmd(input int idx, input int w, input int a, input int d, input string req);
    int act, exp;
    act = log_w[idx] * 4096 + log_a[idx] * 256 + log_d[idx];
    exp = w * 4096 + a * 256 + (w != 0 ? d : 0);
    chk(act == exp, req, act, exp);
  endtask

  task automatic pulse(input bit e, input bit d);
    en_req = e; dis_req = d;
    @(negedge clk);
    en_req = 1'b0; dis_req = 1'b0;
  endtask

  task automatic wait_dones(input int target, input string req);
    int t = 0;
    while (done_cnt < target && t < 3000) begin @(negedge clk); t++; end
    chk(done_cnt >= target, req, done_cnt, target);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog R11 actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, d0, ms, r;
    logic [2:0] rb;
    for (int rr = 0; rr < 8; rr++) begin
      r  = rr;
      rb = 3'(rr);
      ms = 2 + 3 * r;
      ms_cycles = CW'(ms);
      rdy_gap = r % 3; done_lat = r % 4; corrupt = (r == 5);
      pre1 = {4'(r + 3), 4'(15 - r)};
      pre2 = {5'(r * 3 + 1), rb};
      pre3 = {rb[0] ^ rb[1], 6'(r * 5), rb[1]};
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(panel_rst && !busy && !cmd_valid && !seq_done, "R1",
          int'({panel_rst, busy, cmd_valid, seq_done}), 8);

      // R8 disable before any bring-up is dropped
      pulse(1'b0, 1'b1);
      repeat (10) @(negedge clk);
      chk(lcnt == 0 && done_cnt == 0 && !busy_seen && panel_rst, "R8",
          lcnt + done_cnt + int'(busy_seen) + 100 * int'(!panel_rst), 0);

      // first enable: bring-up
      pulse(1'b1, 1'b0);
      wait_dones(1, "R11");
      chk(!panel_rst, "R1", int'(panel_rst), 0);
      chk(gap >= 2 * ms && gap <= 2 * ms + 2, "R2", gap, 2 * ms + 1);
      chk(lcnt == 7, "R3", lcnt, 7);
      chk_cmd(0, 1, 0, 8'h55, "R3");
      chk_cmd(1, 0, 0, 0, "R3");
      chk_cmd(2, 0, 1, 0, "R3");
      chk_cmd(3, 0, 2, 0, "R3");
      chk_cmd(4, 0, 3, 0, "R3");
      chk_cmd(5, 0, 3, 0, "R7");
      chk_cmd(6, 1, 3, int'(pre3 | 8'h01), "R7");
      chk(link_ok == !corrupt, "R3", int'(link_ok), int'(!corrupt));
      chk(chip_id == pre1[7:4] && version == pre1[3:0], "R4",
          int'({chip_id, version}), int'(pre1));
      chk(res_code == pre2[2:0], "R5", int'(res_code), int'(pre2[2:0]));
      chk(res_illegal == (pre2[2:0] == 3'd2 || pre2[2:0] == 3'd3), "R5",
          int'(res_illegal), int'(pre2[2:0] == 3'd2 || pre2[2:0] == 3'd3));
      chk(sw_ctrl == pre3[7], "R6", int'(sw_ctrl), int'(pre3[7]));

      // disable: standby entry
      base = lcnt; d0 = done_cnt;
      pulse(1'b0, 1'b1);
      wait_dones(d0 + 1, "R8");
      chk(lcnt == base + 2, "R8", lcnt - base, 2);
      chk_cmd(base, 0, 3, 0, "R8");
      chk_cmd(base + 1, 1, 3, int'(pre3 & 8'hFE), "R8");
      chk(!panel_rst, "R1", int'(panel_rst), 0);

      // later enable: no bring-up repeat
      base = lcnt; d0 = done_cnt;
      pulse(1'b1, 1'b0);
      wait_dones(d0 + 1, "R7");
      chk(lcnt == base + 2, "R7", lcnt - base, 2);
      chk_cmd(base, 0, 3, 0, "R7");
      chk_cmd(base + 1, 1, 3, int'(pre3 | 8'h01), "R7");

      // R9 queued requests, newest wins
      base = lcnt; d0 = done_cnt;
      pulse(1'b1, 1'b0);
      repeat (2) @(negedge clk);
      pulse(1'b0, 1'b1);
      pulse(1'b1, 1'b0);
      pulse(1'b0, 1'b1);
      wait_dones(d0 + 2, "R9");
      repeat (30) @(negedge clk);
      chk(done_cnt == d0 + 2 && lcnt == base + 4, "R9", done_cnt - d0, 2);
      chk_cmd(base + 3, 1, 3, int'(pre3 & 8'hFE), "R9");
      chk(mregs[3][0] == 1'b0, "R9", int'(mregs[3][0]), 0);

      // R9 simultaneous requests count as enable
      base = lcnt; d0 = done_cnt;
      pulse(1'b0, 1'b1);
      repeat (2) @(negedge clk);
      pulse(1'b1, 1'b1);
      wait_dones(d0 + 2, "R9");
      repeat (30) @(negedge clk);
      chk(done_cnt == d0 + 2, "R9", done_cnt - d0, 2);
      chk_cmd(base + 3, 1, 3, int'(pre3 | 8'h01), "R9");

      // R10 / R11 protocol monitors
      chk(viol == 0, "R10", viol, 0);
      chk(stab_err == 0, "R10", stab_err, 0);
      chk(busy_err == 0, "R11", busy_err, 0);
      chk(dn_err == 0, "R11", dn_err, 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule